// File: doc/BRIEF.md
# Converter Chain Sequencing Controller

This block is the top-level sequencer for a small analog chain that shares one serial bus among three transfer engines. The engines are a programmable-gain preamp writer, an ADC frame reader and a DAC writer. After reset the controller spends a fixed settling interval with every engine held idle. It then programs the preamp gain a set number of times. After that it loops forever, reading one ADC frame and then writing one DAC word.

Only one engine owns the bus at any time. The controller keeps every engine in reset except the current owner. It releases that owner's reset one cycle before pulsing its start. It then watches the owner's busy flag and moves on when the flag drops. The owner's clock, data and select lines are steered onto the shared board pins. Every other select pin sits at its inactive level, and the parallel flash that shares the pins is kept disabled.

Between a read and the following write, the controller converts the channel-0 sample of the latest ADC frame from 14-bit two's complement to a 12-bit offset-binary DAC code.

Top module: `conv_chain_ctrl`

## Requirements
- R1: After reset, all three engines are held in reset and no start is pulsed for INIT_CYCLES cycles (default 16). The first preamp start appears on cycle INIT_CYCLES+1 after reset is released.
- R2: The engines start in the order preamp ×AMP_REPS (default 3), then ADC and DAC alternating for as long as the block runs.
- R3: `amp_word` equals {gain_ch1, gain_ch0} (bits 7:4 and 3:0) as sampled on the last init cycle. Later changes on the gain inputs do not affect it.
- R4: At most one engine reset is deasserted at a time. A start is a one-cycle pulse. It only goes to the engine whose reset was already deasserted in the previous cycle.
- R5: An engine raises its run flag in the cycle after its start. The controller pulses the next start exactly two cycles after the cycle in which the current owner's run flag is first seen low.
- R6: `spi_sck` and `spi_mosi` follow the owning engine's clock and data, and are 0 when no engine owns the bus. The ADC reader drives no data.
- R7: Each non-owned select pin is held at its inactive level: `amp_cs_n` = 1, `ad_conv` = 0, `dac_cs_n` = 1. The owner's select passes through unchanged.
- R8: `adc_miso` carries `spi_miso` while the ADC reader owns the bus and is 0 otherwise.
- R9: `dac_code` resets to 12'h800. At the end of each read it takes the channel-0 sample `adc_frame[27:14]` (two's complement), with the MSB inverted and the two LSBs dropped. It holds that value through the following write.
- R10: `flash_ce_n` is held at 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_ch0 | input | 4 | Preamp channel-0 gain code |
| gain_ch1 | input | 4 | Preamp channel-1 gain code |
| amp_word | output | 8 | Latched gain word for the preamp writer |
| amp_rst | output | 1 | Reset to preamp writer |
| amp_start | output | 1 | Start pulse to preamp writer |
| amp_run | input | 1 | Preamp writer busy flag |
| amp_sck | input | 1 | Preamp writer serial clock |
| amp_mosi | input | 1 | Preamp writer serial data |
| amp_sel_n | input | 1 | Preamp writer select (active low) |
| adc_rst | output | 1 | Reset to ADC reader |
| adc_start | output | 1 | Start pulse to ADC reader |
| adc_run | input | 1 | ADC reader busy flag |
| adc_sck | input | 1 | ADC reader serial clock |
| adc_conv | input | 1 | ADC reader convert strobe (active high) |
| adc_frame | input | 28 | Frame from ADC reader, channel 0 in bits 27:14 |
| adc_miso | output | 1 | Serial data routed to ADC reader |
| dac_rst | output | 1 | Reset to DAC writer |
| dac_start | output | 1 | Start pulse to DAC writer |
| dac_run | input | 1 | DAC writer busy flag |
| dac_sck | input | 1 | DAC writer serial clock |
| dac_mosi | input | 1 | DAC writer serial data |
| dac_sel_n | input | 1 | DAC writer select (active low) |
| dac_code | output | 12 | Offset-binary code for the DAC writer |
| spi_sck | output | 1 | Shared board serial clock |
| spi_mosi | output | 1 | Shared board serial data out |
| spi_miso | input | 1 | Shared board serial data in |
| amp_cs_n | output | 1 | Board preamp select |
| ad_conv | output | 1 | Board ADC convert |
| dac_cs_n | output | 1 | Board DAC select |
| flash_ce_n | output | 1 | Board parallel flash enable (held inactive) |

## Verification
Engine models answer each start with a busy period of random length between 2 and 9 cycles. While busy they drive random clock, data and select bits, so a wrong routing choice or a stale owner shows up on the board pins within a few cycles. The first three reads carry the directed channel-0 values most-negative, most-positive and zero, which separate an uninverted MSB or a wrong bit slice from the correct conversion. Later reads use random frames. The gain inputs are changed right after the first preamp start, which tells a latched gain word from a live one. The start order and the gap timing are checked against a model kept in the bench.

// File: rtl/conv_chain_pkg.sv
package conv_chain_pkg;

    localparam int ADC_W   = 14;
    localparam int DAC_W   = 12;
    localparam int GAIN_W  = 4;
    localparam int FRAME_W = 2 * ADC_W;
    localparam int NUM_ENG = 3;

    localparam int ENG_AMP = 0;
    localparam int ENG_ADC = 1;
    localparam int ENG_DAC = 2;

    // inactive level of each engine's select, bit i for engine i
    localparam logic [NUM_ENG-1:0] SEL_IDLE = 3'b101;

    typedef enum logic [1:0] {
        PH_INIT,
        PH_AMP,
        PH_READ,
        PH_WRITE
    } phase_e;

    typedef enum logic [1:0] {
        ST_PREP,
        ST_KICK,
        ST_WAIT
    } step_e;

    typedef struct packed {
        logic sck;
        logic mosi;
        logic sel;
    } lane_t;

    function automatic logic [NUM_ENG-1:0] owner_mask(phase_e ph);
        logic [NUM_ENG-1:0] m;
        m = '0;
        case (ph)
            PH_AMP:   m[ENG_AMP] = 1'b1;
            PH_READ:  m[ENG_ADC] = 1'b1;
            PH_WRITE: m[ENG_DAC] = 1'b1;
            default:  m = '0;
        endcase
        return m;
    endfunction

    // two's complement sample to offset-binary code of DAC_W bits
    function automatic logic [DAC_W-1:0] to_offset(logic [ADC_W-1:0] s);
        return {~s[ADC_W-1], s[ADC_W-2 -: DAC_W-1]};
    endfunction

endpackage

// File: rtl/cc_seq_fsm.sv
module cc_seq_fsm
    import conv_chain_pkg::*;
#(
    parameter int INIT_CYCLES = 16,
    parameter int AMP_REPS    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENG-1:0] run,
    output phase_e             phase,
    output logic [NUM_ENG-1:0] eng_rst,
    output logic [NUM_ENG-1:0] eng_start,
    output logic               load_gain,
    output logic               read_done
);

    localparam int ICW = $clog2(INIT_CYCLES + 1);
    localparam int RCW = $clog2(AMP_REPS + 1);

    phase_e             phase_q;
    step_e              step_q;
    logic [ICW-1:0]     icnt_q;
    logic [RCW-1:0]     rep_q;
    logic [NUM_ENG-1:0] own;
    logic               own_run;
    logic               last_rep;
    logic               init_end;
    logic               xfer_end;

    always_comb begin
        own      = owner_mask(phase_q);
        own_run  = |(run & own);
        last_rep = (rep_q == RCW'(AMP_REPS - 1));
        init_end = (phase_q == PH_INIT) && (icnt_q == ICW'(INIT_CYCLES - 1));
        xfer_end = (phase_q != PH_INIT) && (step_q == ST_WAIT) && !own_run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INIT;
            step_q  <= ST_PREP;
            icnt_q  <= '0;
            rep_q   <= '0;
        end else if (phase_q == PH_INIT) begin
            if (init_end) begin
                phase_q <= PH_AMP;
                step_q  <= ST_PREP;
                rep_q   <= '0;
            end else begin
                icnt_q <= icnt_q + 1'b1;
            end
        end else begin
            case (step_q)
                ST_PREP: step_q <= ST_KICK;
                ST_KICK: step_q <= ST_WAIT;
                default: begin
                    if (!own_run) begin
                        step_q <= ST_PREP;
                        case (phase_q)
                            PH_AMP: begin
                                if (last_rep) phase_q <= PH_READ;
                                else          rep_q   <= rep_q + 1'b1;
                            end
                            PH_READ: phase_q <= PH_WRITE;
                            default: phase_q <= PH_READ;
                        endcase
                    end
                end
            endcase
        end
    end

    assign phase     = phase_q;
    assign eng_rst   = ~own;
    assign eng_start = (step_q == ST_KICK) ? own : '0;
    assign load_gain = init_end;
    assign read_done = xfer_end && (phase_q == PH_READ);

    // R4
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~eng_rst) <= 1);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (|eng_start) |=> !(|eng_start));

    generate
        for (genvar i = 0; i < NUM_ENG; i++) begin : g_gap
            // R4
            start_gap_chk: assert property (@(posedge clk) disable iff (rst)
                eng_start[i] |-> $past(!eng_rst[i]));
        end
    endgenerate

endmodule

// File: rtl/cc_bus_mux.sv
module cc_bus_mux
    import conv_chain_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  phase_e                     phase,
    input  lane_t [NUM_ENG-1:0]        lanes,
    input  logic                       miso,
    output logic                       sck,
    output logic                       mosi,
    output logic [NUM_ENG-1:0]         sel,
    output logic                       rd_miso
);

    logic [NUM_ENG-1:0] own;

    always_comb begin
        own  = owner_mask(phase);
        sck  = 1'b0;
        mosi = 1'b0;
        for (int i = 0; i < NUM_ENG; i++) begin
            sck  = sck  | (own[i] & lanes[i].sck);
            mosi = mosi | (own[i] & lanes[i].mosi);
        end
        rd_miso = own[ENG_ADC] & miso;
    end

    generate
        for (genvar i = 0; i < NUM_ENG; i++) begin : g_sel
            assign sel[i] = own[i] ? lanes[i].sel : SEL_IDLE[i];
        end
    endgenerate

    // R6 R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INIT) |-> (!sck && !mosi && sel == SEL_IDLE));

    // R8
    miso_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_READ) |-> !rd_miso);

endmodule

// File: rtl/cc_data_regs.sv
module cc_data_regs
    import conv_chain_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  phase_e                phase,
    input  logic                  load_gain,
    input  logic [GAIN_W-1:0]     gain_ch0,
    input  logic [GAIN_W-1:0]     gain_ch1,
    input  logic                  capture,
    input  logic [FRAME_W-1:0]    frame,
    output logic [2*GAIN_W-1:0]   amp_word,
    output logic [DAC_W-1:0]      dac_code
);

    localparam logic [DAC_W-1:0] MID_CODE = DAC_W'(1) << (DAC_W - 1);

    logic [ADC_W-1:0] ch0;

    assign ch0 = frame[FRAME_W-1 -: ADC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_word <= '0;
            dac_code <= MID_CODE;
        end else begin
            if (load_gain) amp_word <= {gain_ch1, gain_ch0};
            if (capture)   dac_code <= to_offset(ch0);
        end
    end

    // R3
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) != PH_INIT) |-> $stable(amp_word));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && $past(phase) == PH_WRITE) |-> $stable(dac_code));

endmodule

// File: rtl/conv_chain_ctrl.sv
module conv_chain_ctrl
    import conv_chain_pkg::*;
#(
    parameter int INIT_CYCLES = 16,
    parameter int AMP_REPS    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GAIN_W-1:0]   gain_ch0,
    input  logic [GAIN_W-1:0]   gain_ch1,
    output logic [2*GAIN_W-1:0] amp_word,
    output logic                amp_rst,
    output logic                amp_start,
    input  logic                amp_run,
    input  logic                amp_sck,
    input  logic                amp_mosi,
    input  logic                amp_sel_n,
    output logic                adc_rst,
    output logic                adc_start,
    input  logic                adc_run,
    input  logic                adc_sck,
    input  logic                adc_conv,
    input  logic [FRAME_W-1:0]  adc_frame,
    output logic                adc_miso,
    output logic                dac_rst,
    output logic                dac_start,
    input  logic                dac_run,
    input  logic                dac_sck,
    input  logic                dac_mosi,
    input  logic                dac_sel_n,
    output logic [DAC_W-1:0]    dac_code,
    output logic                spi_sck,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                amp_cs_n,
    output logic                ad_conv,
    output logic                dac_cs_n,
    output logic                flash_ce_n
);

    phase_e              phase;
    logic [NUM_ENG-1:0]  eng_rst;
    logic [NUM_ENG-1:0]  eng_start;
    logic [NUM_ENG-1:0]  run_vec;
    logic [NUM_ENG-1:0]  sel_vec;
    lane_t [NUM_ENG-1:0] lanes;
    logic                load_gain;
    logic                read_done;

    always_comb begin
        run_vec            = '0;
        run_vec[ENG_AMP]   = amp_run;
        run_vec[ENG_ADC]   = adc_run;
        run_vec[ENG_DAC]   = dac_run;
        lanes[ENG_AMP]     = '{sck: amp_sck, mosi: amp_mosi, sel: amp_sel_n};
        lanes[ENG_ADC]     = '{sck: adc_sck, mosi: 1'b0,     sel: adc_conv};
        lanes[ENG_DAC]     = '{sck: dac_sck, mosi: dac_mosi, sel: dac_sel_n};
    end

    cc_seq_fsm #(
        .INIT_CYCLES (INIT_CYCLES),
        .AMP_REPS    (AMP_REPS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (run_vec),
        .phase     (phase),
        .eng_rst   (eng_rst),
        .eng_start (eng_start),
        .load_gain (load_gain),
        .read_done (read_done)
    );

    cc_bus_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .lanes   (lanes),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .sel     (sel_vec),
        .rd_miso (adc_miso)
    );

    cc_data_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .load_gain (load_gain),
        .gain_ch0  (gain_ch0),
        .gain_ch1  (gain_ch1),
        .capture   (read_done),
        .frame     (adc_frame),
        .amp_word  (amp_word),
        .dac_code  (dac_code)
    );

    assign amp_rst    = eng_rst[ENG_AMP];
    assign adc_rst    = eng_rst[ENG_ADC];
    assign dac_rst    = eng_rst[ENG_DAC];
    assign amp_start  = eng_start[ENG_AMP];
    assign adc_start  = eng_start[ENG_ADC];
    assign dac_start  = eng_start[ENG_DAC];
    assign amp_cs_n   = sel_vec[ENG_AMP];
    assign ad_conv    = sel_vec[ENG_ADC];
    assign dac_cs_n   = sel_vec[ENG_DAC];
    assign flash_ce_n = 1'b1;

    // R10
    flash_off_chk: assert property (@(posedge clk) disable iff (rst)
        flash_ce_n && (amp_rst || adc_rst));

endmodule

// File: tb/conv_chain_ctrl_tb.sv
`timescale 1ns/1ps
module conv_chain_ctrl_tb;

    localparam int INIT_CYCLES = 16;
    localparam int AMP_REPS    = 3;
    localparam int WRITES      = 30;
    localparam int MAX_CYC     = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  gain_ch0, gain_ch1;
    logic [7:0]  amp_word;
    logic        amp_rst, amp_start, adc_rst, adc_start, dac_rst, dac_start;
    logic [27:0] adc_frame;
    logic        adc_miso;
    logic [11:0] dac_code;
    logic        spi_sck, spi_mosi, spi_miso;
    logic        amp_cs_n, ad_conv, dac_cs_n, flash_ce_n;
    logic [2:0]  mrun, msck, mmosi, msel;

    always #4 clk = ~clk;

    conv_chain_ctrl #(.INIT_CYCLES(INIT_CYCLES), .AMP_REPS(AMP_REPS)) u_dut (
        .clk(clk), .rst(rst), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
        .amp_word(amp_word),
        .amp_rst(amp_rst), .amp_start(amp_start), .amp_run(mrun[0]),
        .amp_sck(msck[0]), .amp_mosi(mmosi[0]), .amp_sel_n(msel[0]),
        .adc_rst(adc_rst), .adc_start(adc_start), .adc_run(mrun[1]),
        .adc_sck(msck[1]), .adc_conv(msel[1]), .adc_frame(adc_frame),
        .adc_miso(adc_miso),
        .dac_rst(dac_rst), .dac_start(dac_start), .dac_run(mrun[2]),
        .dac_sck(msck[2]), .dac_mosi(mmosi[2]), .dac_sel_n(msel[2]),
        .dac_code(dac_code),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .amp_cs_n(amp_cs_n), .ad_conv(ad_conv), .dac_cs_n(dac_cs_n),
        .flash_ce_n(flash_ce_n)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int nstart = 0;
    int nwrites = 0;
    int last_drop = -1;
    int busy [3];
    logic [3:0]  g0_ref, g1_ref;
    logic [13:0] last_ch0;
    localparam logic [2:0] IDLE_SEL = 3'b101;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic int exp_engine(input int k);
        if (k < AMP_REPS) return 0;
        return ((k - AMP_REPS) % 2 == 0) ? 1 : 2;
    endfunction

    function automatic logic [11:0] exp_code(input logic [13:0] s);
        int v;
        v = (s >= 14'h2000) ? int'(s) - 16384 : int'(s);
        return 12'((v + 8192) / 4);
    endfunction

    task automatic on_start(input int i);
        logic [13:0] ch0;
        chk(i == exp_engine(nstart), "R2 start order", i, exp_engine(nstart));
        chk(mrun == 3'b000, "R5 start while an engine busy", mrun, 0);
        if (nstart == 0)
            chk(cyc == INIT_CYCLES + 1, "R1 first start cycle", cyc, INIT_CYCLES + 1);
        else
            chk(cyc == last_drop + 2, "R5 start gap", cyc, last_drop + 2);
        if (i == 0) begin
            chk(amp_word == {g1_ref, g0_ref}, "R3 gain word", amp_word, {g1_ref, g0_ref});
            if (nstart == 0) begin
                gain_ch0 = ~g0_ref;
                gain_ch1 = g1_ref ^ 4'h5;
            end
        end else if (i == 1) begin
            case (nstart - AMP_REPS)
                0:       ch0 = 14'h2000;
                2:       ch0 = 14'h1FFF;
                4:       ch0 = 14'h0000;
                default: ch0 = 14'($urandom);
            endcase
            adc_frame = {ch0, 14'($urandom)};
            last_ch0  = ch0;
        end else begin
            chk(dac_code == exp_code(last_ch0), "R9 dac code", dac_code, exp_code(last_ch0));
            nwrites++;
        end
        nstart++;
    endtask

    task automatic cycle_step();
        logic [2:0] st, rs;
        logic       exp_b;
        @(posedge clk);
        cyc++;
        #2;
        st = {dac_start, adc_start, amp_start};
        rs = {dac_rst, adc_rst, amp_rst};
        for (int i = 0; i < 3; i++) begin
            if (st[i] && rs[i]) chk(1'b0, "R4 start with reset held", rs, 0);
            if (rs[i]) begin
                mrun[i] = 1'b0;
                busy[i] = 0;
            end else if (st[i]) begin
                on_start(i);
                mrun[i] = 1'b1;
                busy[i] = 2 + int'($urandom % 8);
            end else if (busy[i] > 0) begin
                busy[i]--;
                if (busy[i] == 0) begin
                    mrun[i]   = 1'b0;
                    last_drop = cyc;
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            if (mrun[i]) begin
                msck[i]  = 1'($urandom);
                mmosi[i] = (i == 1) ? 1'b0 : 1'($urandom);
                msel[i]  = 1'($urandom);
            end else begin
                msck[i] = 1'b0; mmosi[i] = 1'b0; msel[i] = IDLE_SEL[i];
            end
        end
        spi_miso = 1'($urandom);
        #2;
        exp_b = |(mrun & msck);
        chk(spi_sck == exp_b, "R6 sck route", spi_sck, exp_b);
        exp_b = |(mrun & mmosi);
        chk(spi_mosi == exp_b, "R6 mosi route", spi_mosi, exp_b);
        exp_b = mrun[0] ? msel[0] : 1'b1;
        chk(amp_cs_n == exp_b, "R7 amp select", amp_cs_n, exp_b);
        exp_b = mrun[1] ? msel[1] : 1'b0;
        chk(ad_conv == exp_b, "R7 convert", ad_conv, exp_b);
        exp_b = mrun[2] ? msel[2] : 1'b1;
        chk(dac_cs_n == exp_b, "R7 dac select", dac_cs_n, exp_b);
        if (mrun[1]) chk(adc_miso == spi_miso, "R8 miso to reader", adc_miso, spi_miso);
        if (mrun[0] || mrun[2]) chk(adc_miso == 1'b0, "R8 miso blocked", adc_miso, 0);
        chk($countones(~rs) <= 1, "R4 single release", rs, 0);
        if (nstart == 0 && cyc < INIT_CYCLES)
            chk(rs == 3'b111, "R1 init holds resets", rs, 3'b111);
        chk(flash_ce_n == 1'b1, "R10 flash disabled", flash_ce_n, 1);
    endtask

    initial begin
        void'($urandom(32'd2741));
        mrun = '0; msck = '0; mmosi = '0; msel = IDLE_SEL;
        for (int i = 0; i < 3; i++) busy[i] = 0;
        adc_frame = '0;
        spi_miso  = 1'b0;
        g0_ref    = 4'h3;
        g1_ref    = 4'hA;
        gain_ch0  = g0_ref;
        gain_ch1  = g1_ref;
        last_ch0  = '0;
        repeat (3) @(posedge clk);
        #4;
        chk({amp_rst, adc_rst, dac_rst} == 3'b111, "R1 reset holds engines", {amp_rst, adc_rst, dac_rst}, 7);
        chk({amp_start, adc_start, dac_start} == 3'b000, "R4 no start in reset", {amp_start, adc_start, dac_start}, 0);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R6 bus idle in reset", {spi_sck, spi_mosi}, 0);
        chk({amp_cs_n, ad_conv, dac_cs_n} == 3'b101, "R7 selects idle in reset", {amp_cs_n, ad_conv, dac_cs_n}, 5);
        chk(dac_code == 12'h800, "R9 reset code", dac_code, 12'h800);
        chk(flash_ce_n == 1'b1, "R10 flash in reset", flash_ce_n, 1);
        @(posedge clk);
        #1 rst = 1'b0;
        while (nwrites < WRITES && cyc < MAX_CYC) cycle_step();
        if (nwrites < WRITES) chk(1'b0, "watchdog", nwrites, WRITES);
        chk(amp_word == {g1_ref, g0_ref}, "R3 gain word after loop", amp_word, {g1_ref, g0_ref});
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule